// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns serial PCM audio into parallel samples. Three data lines each carry one stereo pair. They share one bit clock and one frame clock, so the block delivers six channels. The framing convention and the word length are static settings. They must only change while the block is held in reset. Data is sent MSB first in two's complement.

The bit clock, the frame clock and the data lines are not used as clocks. They are sampled in the system clock domain, and the block finds bit-clock rising edges there. Data bits and the frame level are taken at each bit-clock rising edge. The system clock should run at least six times faster than the bit clock.

One shared framing controller tracks the bit position and decides when a word is complete. Each line has its own shift register and output register. All lines deliver their samples in the same cycle.

Top module: `pcm_rx`

## Requirements
- R1: While reset is held and after its release, `valid_o` is all zero, `sample_o` is zero and `chan_o` is zero, until a sample is delivered.
- R2: `fmt_i`=0 selects left-justified framing. The frame clock is high for the left half. The MSB is the first bit of a half, and one word is delivered per half.
- R3: `fmt_i`=1 selects I2S-style framing. The frame clock is low for the left half. The MSB comes on the second bit of a half.
- R4: `fmt_i`=2 selects right-justified framing. The frame clock is high for the left half. The LSB is the last bit before a frame-clock change. Each word is delivered at the bit-clock edge where that change is seen.
- R5: `fmt_i`=3 selects DSP framing. A frame-clock pulse one bit wide is seen at one bit-clock edge. The left MSB comes on the next bit, and the right word follows directly after the left LSB.
- R6: `wlen_i` sets the word length: 0 means 16 bits, 1 means 20 bits, 2 or 3 means 24 bits. Shorter words are placed in the upper bits of the 24-bit sample, and the lower bits are zero.
- R7: Every delivered sample is a one-cycle strobe on `valid_o`. All lines strobe in the same cycle. The channel index is 2×line+side, where side 0 is left and side 1 is right. In every format, left is delivered before right.
- R8: No sample is delivered before the first frame-clock change seen after reset. In right-justified mode, that first change delivers nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Serial bit clock, sampled |
| frame_i | input | 1 | Left/right frame clock or DSP sync pulse, sampled |
| sdata_i | input | LINES | Serial data, one stereo pair per line |
| fmt_i | input | 2 | Framing select (see R2 to R5) |
| wlen_i | input | 2 | Word length select (see R6) |
| sample_o | output | LINES×24 | Left-aligned signed sample per line |
| valid_o | output | LINES | Sample strobe per line |
| chan_o | output | LINES×CH_W | Channel index per line |

## Verification
The hardest case to reach is the right-justified look-back. A word becomes known only at the next frame-clock change. So the last right word of a stream needs a trailing half frame, and the first change after reset must deliver nothing. The stimulus covers both. Each run is preceded by an idle half with the frame clock at the level opposite to the first half, and is followed by a zero flush frame whose strobes are accepted but not compared. Every format is run at every word length. The samples are random, mixed with directed extremes such as the most negative value, all ones and single-bit patterns.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

   typedef enum logic [1:0] {
      FMT_LEFT  = 2'd0,
      FMT_I2S   = 2'd1,
      FMT_RIGHT = 2'd2,
      FMT_DSP   = 2'd3
   } rx_fmt_e;

   localparam int MAX_WORD = 24;

   // Word length code to bit count; code 3 falls back to the widest word.
   function automatic int unsigned word_bits(input logic [1:0] code);
      case (code)
         2'd0:    return 16;
         2'd1:    return 20;
         default: return 24;
      endcase
   endfunction

endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o,
   output logic [W-1:0] rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pcm_rx_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("pcm_rx_sync: W must be positive");
   end

   // stg[0] is the newest sample, stg[STAGES] holds the previous settled value
   logic [STAGES:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg <= {stg[STAGES-1:0], async_i};
      end
   end

   assign sync_o = stg[STAGES-1];
   assign rise_o = stg[STAGES-1] & ~stg[STAGES];

endmodule

// File: rtl/pcm_rx_framer.sv
module pcm_rx_framer
   import pcm_rx_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_rise,
   input  logic       fr,
   input  logic [1:0] fmt,
   input  logic [1:0] wlen,
   output logic       emit_o,
   output logic       use_cur_o,
   output logic       right_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if ((2 ** CNT_W) <= 2 * MAX_WORD + 1) begin : g_bad_cnt
      $error("pcm_rx_framer: CNT_W too small for a two-word DSP frame");
   end

   logic             primed, armed, fr_prev;
   logic [CNT_W-1:0] cnt, idx, wb, wb2;
   logic             lvl_edge, dsp_start, restart;
   rx_fmt_e          mode;

   assign mode      = rx_fmt_e'(fmt);
   assign wb        = CNT_W'(word_bits(wlen));
   assign wb2       = CNT_W'(2 * word_bits(wlen));
   assign lvl_edge  = primed && (fr != fr_prev);
   assign dsp_start = primed && fr && !fr_prev;
   assign restart   = (mode == FMT_DSP) ? dsp_start : lvl_edge;

   // position of the bit taken at this rise, counted from the frame boundary
   always_comb begin
      if (restart)              idx = '0;
      else if (cnt == CNT_MAX)  idx = CNT_MAX;
      else                      idx = cnt + 1'b1;
   end

   always_comb begin
      emit_o    = 1'b0;
      use_cur_o = 1'b1;
      right_o   = 1'b0;
      case (mode)
         FMT_LEFT: begin
            emit_o  = (idx == wb - 1'b1);
            right_o = !fr;
         end
         FMT_I2S: begin
            emit_o  = (idx == wb);
            right_o = fr;
         end
         FMT_RIGHT: begin
            emit_o    = lvl_edge && armed;
            use_cur_o = 1'b0;
            right_o   = !fr_prev;
         end
         default: begin
            emit_o  = (idx == wb) || (idx == wb2);
            right_o = (idx == wb2);
         end
      endcase
      emit_o = emit_o && bit_rise;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed  <= 1'b0;
         armed   <= 1'b0;
         fr_prev <= 1'b0;
         cnt     <= CNT_MAX;
      end else if (bit_rise) begin
         primed  <= 1'b1;
         fr_prev <= fr;
         cnt     <= idx;
         if (lvl_edge) armed <= 1'b1;
      end
   end

   // R8: nothing leaves before a frame boundary has been observed
   assert_quiet_before_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !emit_o);

   // R5: a DSP right word is only taken a whole word after the left one
   assert_dsp_right_after_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (emit_o && mode == FMT_DSP && right_o) |-> (cnt == wb2 - 1'b1));

endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
   import pcm_rx_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int CH_W     = 3,
   parameter int LANE_IDX = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bit_rise,
   input  logic                din,
   input  logic                emit,
   input  logic                use_cur,
   input  logic                right,
   input  logic [1:0]          wlen,
   output logic [SAMPLE_W-1:0] sample_o,
   output logic                valid_o,
   output logic [CH_W-1:0]     chan_o
);

   if (SAMPLE_W < MAX_WORD) begin : g_bad_width
      $error("pcm_rx_lane: SAMPLE_W must hold the widest word");
   end

   logic [SAMPLE_W-1:0] shreg, full, aligned;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        shreg <= '0;
      else if (bit_rise) shreg <= {shreg[SAMPLE_W-2:0], din};
   end

   // word ends either with the bit taken now or with the one before it
   assign full    = use_cur ? {shreg[SAMPLE_W-2:0], din} : shreg;
   assign aligned = full << (SAMPLE_W - int'(word_bits(wlen)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_o <= '0;
         valid_o  <= 1'b0;
         chan_o   <= '0;
      end else begin
         valid_o <= emit;
         if (emit) begin
            sample_o <= aligned;
            chan_o   <= CH_W'(2 * LANE_IDX + (right ? 1 : 0));
         end
      end
   end

endmodule

// File: rtl/pcm_rx.sv
module pcm_rx
   import pcm_rx_pkg::*;
#(
   parameter int LINES      = 3,
   parameter int SAMPLE_W   = 24,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W      = 7,
   localparam int CH_W      = (2 * LINES > 2) ? $clog2(2 * LINES) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bclk_i,
   input  logic                      frame_i,
   input  logic [LINES-1:0]          sdata_i,
   input  logic [1:0]                fmt_i,
   input  logic [1:0]                wlen_i,
   output logic [LINES*SAMPLE_W-1:0] sample_o,
   output logic [LINES-1:0]          valid_o,
   output logic [LINES*CH_W-1:0]     chan_o
);

   localparam int PW = LINES + 2;

   if (LINES < 1) begin : g_bad_lines
      $error("pcm_rx: LINES must be at least 1");
   end

   logic [PW-1:0] pin_sync, pin_rise;
   logic          emit, use_cur, right;

   pcm_rx_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({sdata_i, frame_i, bclk_i}),
      .sync_o  (pin_sync),
      .rise_o  (pin_rise)
   );

   pcm_rx_framer #(.CNT_W(CNT_W)) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_rise  (pin_rise[0]),
      .fr        (pin_sync[1]),
      .fmt       (fmt_i),
      .wlen      (wlen_i),
      .emit_o    (emit),
      .use_cur_o (use_cur),
      .right_o   (right)
   );

   for (genvar l = 0; l < LINES; l++) begin : g_lane
      pcm_rx_lane #(.SAMPLE_W(SAMPLE_W), .CH_W(CH_W), .LANE_IDX(l)) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .bit_rise (pin_rise[0]),
         .din      (pin_sync[2+l]),
         .emit     (emit),
         .use_cur  (use_cur),
         .right    (right),
         .wlen     (wlen_i),
         .sample_o (sample_o[l*SAMPLE_W +: SAMPLE_W]),
         .valid_o  (valid_o[l]),
         .chan_o   (chan_o[l*CH_W +: CH_W])
      );

      assert_pad16_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_o[l] && wlen_i == 2'd0) |-> (sample_o[l*SAMPLE_W +: 8] == '0));

      assert_pad20_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_o[l] && wlen_i == 2'd1) |-> (sample_o[l*SAMPLE_W +: 4] == '0));
   end

   assert_lines_together_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o == '0) || (valid_o == '1));

   assert_single_cycle_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o != '0) |=> (valid_o == '0));

endmodule

// File: tb/tb_pcm_rx.sv
module tb_pcm_rx;

   localparam int LINES = 3;
   localparam int CH_W  = 3;
   localparam int NFR   = 6;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 bclk = 1'b0;
   logic                 frame = 1'b0;
   logic [LINES-1:0]     sdata = '0;
   logic [1:0]           fmt = '0;
   logic [1:0]           wlen = '0;
   logic [LINES*24-1:0]  sample_o;
   logic [LINES-1:0]     valid_o;
   logic [LINES*CH_W-1:0] chan_o;

   int    n_chk = 0;
   int    n_err = 0;
   bit    flushing = 1'b0;
   bit    done = 1'b0;
   int    pre_strobes = 0;
   string cur_req = "R2";
   logic [26:0] q [LINES][$];

   always #2.5 clk = ~clk;

   pcm_rx dut (
      .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .frame_i(frame),
      .sdata_i(sdata), .fmt_i(fmt), .wlen_i(wlen),
      .sample_o(sample_o), .valid_o(valid_o), .chan_o(chan_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic int wbits(input logic [1:0] c);
      return (c == 2'd0) ? 16 : (c == 2'd1) ? 20 : 24;
   endfunction

   function automatic logic [23:0] align(input logic [23:0] v, input int w);
      return v << (24 - w);
   endfunction

   // monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n && valid_o != '0) begin
         pre_strobes++;
         if (valid_o != '1) check(1'b0, "R7", "lines not together", 32'(valid_o), 32'h7);
         for (int l = 0; l < LINES; l++) begin
            if (valid_o[l]) begin
               if (q[l].size() == 0) begin
                  if (!flushing) check(1'b0, "R8", "unexpected strobe", 32'(sample_o[l*24 +: 24]), 32'h0);
               end else begin
                  logic [26:0] e;
                  e = q[l].pop_front();
                  check(sample_o[l*24 +: 24] == e[23:0], {cur_req, "/R6"}, "sample",
                        32'(sample_o[l*24 +: 24]), 32'(e[23:0]));
                  check(chan_o[l*CH_W +: CH_W] == e[26:24], "R7", "channel index",
                        32'(chan_o[l*CH_W +: CH_W]), 32'(e[26:24]));
               end
            end
         end
      end
   end

   task automatic slot(input logic f, input logic [LINES-1:0] d);
      bclk = 1'b0; frame = f; sdata = d;
      repeat (4) @(posedge clk);
      #1 bclk = 1'b1;
      repeat (4) @(posedge clk);
      #1;
   endtask

   task automatic send_frame(input logic [23:0] lv [LINES], input logic [23:0] rv [LINES]);
      int w;
      logic [LINES-1:0] d;
      w = wbits(wlen);
      if (fmt == 2'd3) begin
         for (int k = 0; k < 64; k++) begin
            for (int l = 0; l < LINES; l++) begin
               if (k >= 1 && k <= w)          d[l] = lv[l][w-k];
               else if (k > w && k <= 2 * w)  d[l] = rv[l][2*w-k];
               else                           d[l] = 1'b0;
            end
            slot(k == 0, d);
         end
      end else begin
         for (int h = 0; h < 2; h++) begin
            for (int k = 0; k < 32; k++) begin
               logic f;
               f = (fmt == 2'd1) ? (h == 1) : (h == 0);
               for (int l = 0; l < LINES; l++) begin
                  logic [23:0] v;
                  v = (h == 0) ? lv[l] : rv[l];
                  d[l] = 1'b0;
                  if (fmt == 2'd0 && k < w)                 d[l] = v[w-1-k];
                  if (fmt == 2'd1 && k >= 1 && k <= w)      d[l] = v[w-k];
                  if (fmt == 2'd2 && k >= 32 - w)           d[l] = v[31-k];
               end
               slot(f, d);
            end
         end
      end
   endtask

   function automatic logic [23:0] pick(input int fr, input int l, input int side, input int w);
      logic [23:0] m;
      m = (24'h1 << w) - 1;
      case ((fr * 6 + l * 2 + side) % 12)
         0:  return m >> 1;               // largest positive
         1:  return 24'h1 << (w - 1);     // most negative
         2:  return m;                    // minus one
         3:  return 24'h0;
         4:  return 24'h1;                // LSB only
         5:  return m & 24'h555555;
         default: return $urandom & m;
      endcase
   endfunction

   task automatic run(input logic [1:0] f, input logic [1:0] wl, input string req);
      logic [23:0] lv [LINES];
      logic [23:0] rv [LINES];
      logic [23:0] zl [LINES];
      int w;
      rst_n = 1'b0; fmt = f; wlen = wl; cur_req = req; flushing = 1'b0;
      bclk = 1'b0; frame = 1'b0; sdata = '0;
      for (int l = 0; l < LINES; l++) q[l].delete();
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      w = wbits(wl);
      pre_strobes = 0;
      // idle half with the frame clock opposite to the first half's level
      for (int k = 0; k < 32; k++) slot(f == 2'd1, '0);
      check(pre_strobes == 0, "R8", "strobe during idle lead-in", 32'(pre_strobes), 32'h0);
      for (int fr = 0; fr < NFR; fr++) begin
         for (int l = 0; l < LINES; l++) begin
            lv[l] = pick(fr, l, 0, w);
            rv[l] = pick(fr, l, 1, w);
            q[l].push_back({3'(2 * l), align(lv[l], w)});
            q[l].push_back({3'(2 * l + 1), align(rv[l], w)});
         end
         send_frame(lv, rv);
      end
      flushing = 1'b1;
      for (int l = 0; l < LINES; l++) zl[l] = '0;
      send_frame(zl, zl);
      for (int l = 0; l < LINES; l++)
         check(q[l].size() == 0, req, "samples left undelivered", 32'(q[l].size()), 32'h0);
      flushing = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check(valid_o == '0, "R1", "valid in reset", 32'(valid_o), 32'h0);
      check(sample_o == '0, "R1", "sample in reset", sample_o[31:0], 32'h0);
      #1 rst_n = 1'b1;
      repeat (5) @(posedge clk);
      #1;
      check(valid_o == '0 && chan_o == '0, "R1", "outputs after release", 32'(valid_o), 32'h0);
      for (int wl = 0; wl < 4; wl++) begin
         run(2'd0, 2'(wl), "R2");
         run(2'd1, 2'(wl), "R3");
         run(2'd2, 2'(wl), "R4");
         run(2'd3, 2'(wl), "R5");
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: run did not finish actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule